// File: doc/BRIEF.md
# Unpacked-Digit Adjust Execution Unit

This unit decodes and executes a two-byte instruction that prepares a 16-bit accumulator for a following binary division. The accumulator holds two unpacked digits, the more significant one in its high byte and the less significant one in its low byte. The unit folds them into one binary byte: the high digit is multiplied by a number base and added to the low digit. The base comes from the instruction's second byte, so decimal, octal, base 12 or any other 8-bit base can be used.

Instruction bytes arrive one per cycle, each qualified by a valid strobe. A small state machine tracks the instruction. In state IDLE it waits for the opcode byte D5h; the transition IDLE→GOT_OPCODE takes that byte and samples the mode flag and the lock indication. In GOT_OPCODE it waits, through any number of idle cycles, for the base byte. The transition GOT_OPCODE→EXECUTE captures the base and the accumulator value. EXECUTE lasts exactly one cycle and always returns to IDLE (EXECUTE→IDLE). In that cycle the unit either presents the written-back accumulator with its sign, zero and parity flags, or it raises an invalid-opcode trap. A trap happens when the opcode was marked lock-prefixed or arrived in 64-bit mode.

Overflow, auxiliary-carry and carry flags are not produced. A caller keeps its previous values for them.

Top module: `digit_fold_unit`

## Requirements
- R1: After reset the state machine is in IDLE and both `done_pulse` and `trap_pulse` are low.
- R2: In IDLE a valid byte equal to D5h moves the machine to GOT_OPCODE. Any other valid byte in IDLE is ignored: no pulse follows and a later D5h still starts an instruction.
- R3: In GOT_OPCODE the next valid byte is taken as the base, and `acc_in` is sampled in that same cycle. Cycles with `in_valid` low are waited out. The result pulse is high in the cycle right after the base byte is accepted.
- R4: On `done_pulse`, `acc_out[7:0]` equals (low byte + high byte × base) modulo 256 for every base value from 00h to FFh.
- R5: On `done_pulse`, `acc_out[15:8]` is 00h.
- R6: On `done_pulse`, `flag_sign` equals `acc_out[7]` and `flag_zero` is 1 exactly when `acc_out[7:0]` is 00h. `flag_parity` is 1 exactly when `acc_out[7:0]` has an even number of 1 bits.
- R7: If `wide_mode` is 1 in the cycle the opcode is accepted, the instruction ends with `trap_pulse` and no `done_pulse`. With `done_pulse` low, the accumulator and flags are not written.
- R8: If `lock_seen` is 1 in the cycle the opcode is accepted, the instruction traps in either mode. The values of `wide_mode` and `lock_seen` in later cycles have no effect on that instruction.
- R9: Each instruction produces exactly one single-cycle pulse, either done or trap. A byte offered during the EXECUTE cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte strobe |
| in_byte | input | 8 | Instruction byte |
| wide_mode | input | 1 | 1 when the core runs in 64-bit mode |
| lock_seen | input | 1 | Lock prefix present on the instruction |
| acc_in | input | 16 | Current accumulator value |
| done_pulse | output | 1 | Write-back strobe for accumulator and flags |
| trap_pulse | output | 1 | Invalid-opcode exception strobe |
| acc_out | output | 16 | New accumulator value, valid with done_pulse |
| flag_sign | output | 1 | Sign flag, valid with done_pulse |
| flag_zero | output | 1 | Zero flag, valid with done_pulse |
| flag_parity | output | 1 | Parity flag, valid with done_pulse |

## Verification
A done or trap pulse is due in the cycle after the clock edge that accepts the base byte. That is two edges after the opcode when no idle cycles separate the bytes, and later by one edge for each idle cycle. The driver pushes the expected outcome into a queue when it offers the base byte. A monitor samples on the falling edge, so it sees the pulse half a cycle after the edge that raised it. Every pulse must match the head of the queue, and a pulse with an empty queue is a failure. Stretches where nothing may happen, after ignored bytes or after a byte offered during EXECUTE, are sampled cycle by cycle for silence.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_GOT_OPCODE = 2'd1,
        ST_EXECUTE    = 2'd2
    } dfu_state_e;
endpackage

// File: rtl/dfu_seq.sv
// Instruction sequencer: opcode recognition, base capture, trap sampling.
module dfu_seq
    import dfu_pkg::*;
#(
    parameter int          W   = 8,
    parameter logic [7:0]  OPC = 8'hD5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_byte,
    input  logic             wide_mode,
    input  logic             lock_seen,
    output dfu_state_e       state,
    output logic [W-1:0]     base_q,
    output logic             trap_q,
    output logic             capture
);
    dfu_state_e state_nx;
    logic       opc_hit;

    assign opc_hit = in_valid && (in_byte == W'(OPC));

    // next-state logic
    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE:       if (opc_hit) state_nx = ST_GOT_OPCODE;
            ST_GOT_OPCODE: if (in_valid) begin
                               state_nx = ST_EXECUTE;
                               capture  = 1'b1;
                           end
            ST_EXECUTE:    state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            trap_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && opc_hit) trap_q <= wide_mode | lock_seen;
            if (capture)                     base_q <= in_byte;
        end
    end

    // R9: execute lasts one cycle
    a_r9_exec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EXECUTE |=> state == ST_IDLE);

    // R3: execute only after a valid byte in GOT_OPCODE
    a_r3_exec_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GOT_OPCODE && !in_valid) |=> state == ST_GOT_OPCODE);

    // R2: foreign bytes in IDLE are ignored
    a_r2_ignore_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(in_valid && in_byte == W'(OPC))) |=> state == ST_IDLE);
endmodule

// File: rtl/dfu_fold.sv
// Digit fold: low + high * base, truncated to W bits.
module dfu_fold #(
    parameter int W = 8
) (
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] base,
    output logic [W-1:0] res
);
    localparam int PW = 2 * W + 1;
    logic [PW-1:0] prod;
    logic [PW-1:0] sum;

    always_comb begin
        prod = PW'(hi) * PW'(base);
        sum  = prod + PW'(lo);
        res  = sum[W-1:0];
    end
endmodule

// File: rtl/dfu_flags.sv
// Sign, zero and parity of a W-bit value.
module dfu_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic         sign,
    output logic         zero,
    output logic         parity
);
    logic [W:0] chain;
    assign chain[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_par
        assign chain[i+1] = chain[i] ^ val[i];
    end

    assign sign   = val[W-1];
    assign zero   = (val == '0);
    assign parity = chain[W];
endmodule

// File: rtl/digit_fold_unit.sv
module digit_fold_unit
    import dfu_pkg::*;
#(
    parameter int         W   = 8,
    parameter logic [7:0] OPC = 8'hD5,
    localparam int        AW  = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_byte,
    input  logic          wide_mode,
    input  logic          lock_seen,
    input  logic [AW-1:0] acc_in,
    output logic          done_pulse,
    output logic          trap_pulse,
    output logic [AW-1:0] acc_out,
    output logic          flag_sign,
    output logic          flag_zero,
    output logic          flag_parity
);
    dfu_state_e    state;
    logic [W-1:0]  base_q;
    logic          trap_q;
    logic          capture;
    logic [AW-1:0] acc_q;
    logic [W-1:0]  folded;
    logic          f_s, f_z, f_p;

    dfu_seq #(.W(W), .OPC(OPC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .wide_mode (wide_mode),
        .lock_seen (lock_seen),
        .state     (state),
        .base_q    (base_q),
        .trap_q    (trap_q),
        .capture   (capture)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (capture) acc_q <= acc_in;
    end

    dfu_fold #(.W(W)) u_fold (
        .hi   (acc_q[AW-1:W]),
        .lo   (acc_q[W-1:0]),
        .base (base_q),
        .res  (folded)
    );

    dfu_flags #(.W(W)) u_flags (
        .val    (folded),
        .sign   (f_s),
        .zero   (f_z),
        .parity (f_p)
    );

    // output process
    always_comb begin
        done_pulse  = 1'b0;
        trap_pulse  = 1'b0;
        acc_out     = '0;
        flag_sign   = 1'b0;
        flag_zero   = 1'b0;
        flag_parity = 1'b0;
        unique case (state)
            ST_EXECUTE: begin
                if (trap_q) begin
                    trap_pulse = 1'b1;
                end else begin
                    done_pulse  = 1'b1;
                    acc_out     = {{W{1'b0}}, folded};
                    flag_sign   = f_s;
                    flag_zero   = f_z;
                    flag_parity = f_p;
                end
            end
            default: ;
        endcase
    end

    // R6: zero flag agrees with written low byte
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> flag_zero == (acc_out[W-1:0] == '0));

    // R6: sign flag agrees with written low byte
    a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> flag_sign == acc_out[W-1]);

    // R7: a trap writes nothing
    a_r7_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (!done_pulse && acc_out == '0));

    // R9: pulses last one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse || trap_pulse) |=> !(done_pulse || trap_pulse));
endmodule

// File: tb/digit_fold_unit_bench.sv
module digit_fold_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        wide_mode = 1'b0;
    logic        lock_seen = 1'b0;
    logic [15:0] acc_in = 16'h0000;
    logic        done_pulse, trap_pulse;
    logic [15:0] acc_out;
    logic        flag_sign, flag_zero, flag_parity;

    always #10 clk = ~clk;

    digit_fold_unit u_digit_fold_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .wide_mode(wide_mode), .lock_seen(lock_seen), .acc_in(acc_in),
        .done_pulse(done_pulse), .trap_pulse(trap_pulse), .acc_out(acc_out),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_parity(flag_parity)
    );

    typedef struct {
        logic        trap;
        logic [15:0] acc;
        logic        s, z, p;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (done_pulse || trap_pulse)) begin
            if (exp_q.size() == 0) begin
                check(0, "R9", $sformatf("unexpected pulse done=%0b trap=%0b, expected none",
                                         done_pulse, trap_pulse));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.trap) begin
                    check(trap_pulse && !done_pulse, e.tag,
                          $sformatf("done=%0b trap=%0b, expected trap only", done_pulse, trap_pulse));
                end else begin
                    check(done_pulse && !trap_pulse && acc_out == e.acc &&
                          flag_sign == e.s && flag_zero == e.z && flag_parity == e.p, e.tag,
                          $sformatf("done=%0b acc=%h s%0b z%0b p%0b, expected acc=%h s%0b z%0b p%0b",
                                    done_pulse, acc_out, flag_sign, flag_zero, flag_parity,
                                    e.acc, e.s, e.z, e.p));
                end
            end
        end
    end

    // driver: one instruction; gap idle cycles between opcode and base
    task automatic run_instr(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] base,
                             input bit mode, input bit lock, input int gap, input string tag);
        exp_t e;
        logic [7:0] r;
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'hD5; wide_mode = mode; lock_seen = lock;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0; in_byte = 8'hD5; wide_mode = ~mode; lock_seen = ~lock;
        end
        @(negedge clk);
        in_valid = 1'b1; in_byte = base; acc_in = {hi, lo};
        wide_mode = 1'b0; lock_seen = 1'b0;   // R8: only opcode-cycle values count
        r = 8'((16'(hi) * 16'(base) + 16'(lo)) & 16'h00FF);
        e.trap = mode | lock;
        e.acc  = {8'h00, r};
        e.s    = r[7];
        e.z    = (r == 8'h00);
        e.p    = ~(^r);
        e.tag  = tag;
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0; in_byte = 8'h00;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!done_pulse && !trap_pulse, tag,
                  $sformatf("done=%0b trap=%0b, expected 0 0", done_pulse, trap_pulse));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] bases [5] = '{8'd2, 8'd8, 8'd10, 8'd12, 8'd16};
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done_pulse && !trap_pulse, "R1",
              $sformatf("done=%0b trap=%0b, expected 0 0", done_pulse, trap_pulse));
        rst_n = 1'b1;
        quiet(2, "R1");

        // R2: foreign bytes ignored in IDLE
        @(negedge clk); in_valid = 1'b1; in_byte = 8'h0A;
        @(negedge clk); in_byte = 8'hD4;
        @(negedge clk); in_byte = 8'h37;
        @(negedge clk); in_valid = 1'b0;
        quiet(3, "R2");
        run_instr(8'd4, 8'd7, 8'd10, 0, 0, 0, "R2");

        // R4 R5 R6: digit sweep over several bases
        foreach (bases[b])
            for (int h = 0; h < 16; h++)
                for (int l = 0; l < 16; l++)
                    run_instr(8'(h), 8'(l), bases[b], 0, 0, 0, "R4");

        // R4: truncation and extreme bases
        run_instr(8'hFF, 8'hFF, 8'hFF, 0, 0, 0, "R4");
        run_instr(8'd26, 8'd0, 8'd10, 0, 0, 0, "R4");
        run_instr(8'd25, 8'd6, 8'd10, 0, 0, 0, "R5");
        run_instr(8'h80, 8'h00, 8'h02, 0, 0, 0, "R6");
        run_instr(8'd9, 8'd9, 8'h00, 0, 0, 0, "R4");
        run_instr(8'h7F, 8'h01, 8'h01, 0, 0, 0, "R6");
        for (int k = 0; k < 256; k += 17)
            run_instr(8'(k), 8'(255 - k), 8'(k ^ 8'h5A), 0, 0, 0, "R4");

        // R3: idle cycles between opcode and base
        run_instr(8'd3, 8'd5, 8'd12, 0, 0, 3, "R3");
        run_instr(8'd7, 8'd7, 8'd8, 0, 0, 1, "R3");

        // R7 R8: traps
        run_instr(8'd1, 8'd2, 8'd10, 1, 0, 0, "R7");
        run_instr(8'd1, 8'd2, 8'd10, 0, 1, 0, "R8");
        run_instr(8'd1, 8'd2, 8'd10, 1, 1, 2, "R8");
        run_instr(8'd2, 8'd3, 8'd10, 0, 0, 2, "R8");

        // R9: byte offered during execute ignored
        @(negedge clk); in_valid = 1'b1; in_byte = 8'hD5;
        @(negedge clk); in_byte = 8'd10; acc_in = 16'h0102;
        begin
            exp_t e;
            e.trap = 0; e.acc = 16'h000C; e.s = 0; e.z = 0; e.p = 1; e.tag = "R9";
            exp_q.push_back(e);
        end
        @(negedge clk); in_byte = 8'hD5;    // execute cycle
        @(negedge clk); in_valid = 1'b1; in_byte = 8'd10;
        @(negedge clk); in_valid = 1'b0;
        quiet(4, "R9");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9",
              $sformatf("%0d results outstanding, expected 0", exp_q.size()));
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule